// File: doc/BRIEF.md
# DMA Descriptor List Builder

This block turns one transfer request into a short scatter table that a bus-master DMA engine can fetch later. A request gives a byte-aligned physical start address, a sector count and a direction bit. The builder splits the transfer into regions so that no region crosses a 64 KiB page boundary. It then streams the table out as 32-bit words through a simple write port, which feeds a small descriptor memory.

Each table entry takes two words. The first word is the region's physical base address. The second word holds a 16-bit byte count and an end-of-table flag in the top bit. The table always has three entries (six words), and any entry the transfer does not need is written with a zero count. An odd start address is rejected: the builder raises an error and writes nothing.

The builder accepts one request at a time. A start pulse that arrives while a table is being written is ignored.

Top module: `dlb_builder`

## Requirements
- R1: When start_i is sampled while idle and addr_i bit 0 is 1, the next cycle shows err_o=1 and done_o=1, entries_o=0, busy_o=0. No word is ever written for that request, and err_o stays high until the next accepted request.
- R2: The transfer length in bytes is sectors_i times 512. A sectors_i value of 0 stands for 256 sectors (131072 bytes).
- R3: Word 0 (base of entry 0) equals the request address. Words 2 and 4 (the bases of entries 1 and 2) are each the next 64 KiB boundary above the previous entry's base, computed modulo 2^32.
- R4: Entry 0 gets the lesser of the total length and the room up to the next 64 KiB boundary. Each further entry gets the lesser of what remains and 65536. A transfer that exactly fills the room up to a boundary uses only one entry there. At most three entries are used.
- R5: entries_o reports the number of entries with a nonzero length (1 to 3). Bit 31 of a count word (words 1, 3, 5) is 1 only in the count word of entry entries_o-1.
- R6: A count word carries the entry's byte length in bits 15:0 and zeros in bits 30:16. A full 65536-byte entry stores 0 in bits 15:0.
- R7: An unused entry is still written: its base word follows R3 and its count word is all zeros.
- R8: For an accepted request, words 0 to 5 appear on wr_data_o with wr_en_o=1 and wr_idx_o equal to the word number. They appear on six consecutive cycles, the first being the second cycle after the start edge. done_o is 1 only in the cycle of word 5. busy_o is 1 from the cycle after acceptance until word 5.
- R9: A start_i pulse while busy_o=1 has no effect: the words written, entries_o and dir_o are those of the request in progress.
- R10: dir_o holds the dir_i value of the last accepted request from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse |
| addr_i | input | 32 | Physical start address of the transfer |
| sectors_i | input | 8 | Sector count, 0 means 256 |
| dir_i | input | 1 | Transfer direction, latched on acceptance |
| wr_en_o | output | 1 | Descriptor memory write enable |
| wr_idx_o | output | 3 | Word index within the table |
| wr_data_o | output | 32 | Word to store |
| busy_o | output | 1 | Table being written |
| done_o | output | 1 | One-cycle completion (or rejection) marker |
| err_o | output | 1 | Last request rejected for an odd address |
| entries_o | output | 2 | Number of entries used by the last request |
| dir_o | output | 1 | Direction of the last accepted request |

## Verification
The assertions check the following on every cycle: the word index steps up without gaps, completion coincides with the final word, an error never comes with a write, the end flag sits only on the last used entry, count words keep their middle bits clear, unused entries carry zero counts, and the entry count stays stable while busy. Only the bench scenarios can show that the actual base addresses and lengths are right. These include page-aligned starts, starts two bytes below a boundary, wrap-around at the top of the address space, exact fits, the 256-sector encoding, and a start pulse injected mid-table.

// File: rtl/dlb_pkg.sv
package dlb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } dlb_state_e;
endpackage

// File: rtl/dlb_size_calc.sv
// Converts a sector count into a byte length; a zero count encodes the
// largest representable count plus one.
module dlb_size_calc #(
  parameter int SEC_W   = 8,
  parameter int SECT_LG = 9,
  localparam int TOT_W  = SEC_W + 1 + SECT_LG
) (
  input  logic [SEC_W-1:0] sectors_i,
  output logic [TOT_W-1:0] total_o
);
  logic [TOT_W-1:0] nsec;

  always_comb begin
    if (sectors_i == '0) nsec = TOT_W'(1) << SEC_W;
    else                 nsec = TOT_W'(sectors_i);
    total_o = nsec << SECT_LG;
  end
endmodule

// File: rtl/dlb_region_split.sv
// Walks the transfer page by page and cuts it into NDESC regions.
module dlb_region_split #(
  parameter int ADDR_W  = 32,
  parameter int TOT_W   = 18,
  parameter int PAGE_LG = 16,
  parameter int NDESC   = 3,
  localparam int ROOM_W = PAGE_LG + 1,
  localparam int UW     = $clog2(NDESC + 1),
  localparam int MW     = (TOT_W > ROOM_W) ? TOT_W : ROOM_W
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [TOT_W-1:0]              total_i,
  output logic [NDESC-1:0][ADDR_W-1:0]  base_o,
  output logic [NDESC-1:0][ROOM_W-1:0]  cnt_o,
  output logic [UW-1:0]                 used_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_LG){1'b0}}, {PAGE_LG{1'b1}}};
  localparam logic [ADDR_W-1:0] PAGE_SIZE = {{(ADDR_W-PAGE_LG-1){1'b0}}, 1'b1, {PAGE_LG{1'b0}}};

  always_comb begin
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] nxt;
    logic [MW-1:0]     rem;
    logic [MW-1:0]     room;
    logic [MW-1:0]     take;
    cur    = addr_i;
    rem    = MW'(total_i);
    used_o = '0;
    for (int i = 0; i < NDESC; i++) begin
      nxt       = (cur & ~PAGE_MASK) + PAGE_SIZE;
      room      = MW'(ROOM_W'(nxt - cur));
      take      = (rem > room) ? room : rem;
      base_o[i] = cur;
      cnt_o[i]  = ROOM_W'(take);
      rem       = rem - take;
      if (take != '0) used_o = used_o + UW'(1);
      cur       = nxt;
    end
  end
endmodule

// File: rtl/dlb_word_seq.sv
// Latches a split request and streams it out as base/count word pairs.
module dlb_word_seq
  import dlb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int PAGE_LG = 16,
  parameter int NDESC   = 3,
  localparam int ROOM_W = PAGE_LG + 1,
  localparam int UW     = $clog2(NDESC + 1),
  localparam int NWORDS = 2 * NDESC,
  localparam int IW     = $clog2(NWORDS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          odd_i,
  input  logic                          dir_i,
  input  logic [NDESC-1:0][ADDR_W-1:0]  base_i,
  input  logic [NDESC-1:0][ROOM_W-1:0]  cnt_i,
  input  logic [UW-1:0]                 used_i,
  output logic                          wr_en_o,
  output logic [IW-1:0]                 wr_idx_o,
  output logic [DATA_W-1:0]             wr_data_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic [UW-1:0]                 entries_o,
  output logic                          dir_o
);
  dlb_state_e                    st;
  logic [IW-1:0]                 idx;
  logic [NDESC-1:0][ADDR_W-1:0]  base_q;
  logic [NDESC-1:0][ROOM_W-1:0]  cnt_q;
  logic [DATA_W-1:0]             word_c;
  int                            slot;

  always_comb begin
    slot   = int'(idx) / 2;
    word_c = '0;
    if (slot < NDESC) begin
      if (!idx[0]) begin
        word_c = DATA_W'(base_q[slot]);
      end else begin
        word_c[PAGE_LG-1:0] = cnt_q[slot][PAGE_LG-1:0];
        word_c[DATA_W-1]    = (slot == int'(entries_o) - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      entries_o <= '0;
      dir_o     <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (odd_i) begin
              err_o     <= 1'b1;
              done_o    <= 1'b1;
              entries_o <= '0;
            end else begin
              err_o     <= 1'b0;
              base_q    <= base_i;
              cnt_q     <= cnt_i;
              entries_o <= used_i;
              dir_o     <= dir_i;
              idx       <= '0;
              busy_o    <= 1'b1;
              st        <= ST_EMIT;
            end
          end
        end
        ST_EMIT: begin
          wr_en_o   <= 1'b1;
          wr_idx_o  <= idx;
          wr_data_o <= word_c;
          if (int'(idx) == NWORDS - 1) begin
            st     <= ST_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
            idx    <= '0;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlb_builder.sv
module dlb_builder #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SEC_W   = 8,
  parameter int SECT_LG = 9,
  parameter int PAGE_LG = 16,
  parameter int NDESC   = 3,
  localparam int TOT_W  = SEC_W + 1 + SECT_LG,
  localparam int ROOM_W = PAGE_LG + 1,
  localparam int UW     = $clog2(NDESC + 1),
  localparam int IW     = $clog2(2 * NDESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEC_W-1:0]  sectors_i,
  input  logic              dir_i,
  output logic              wr_en_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [UW-1:0]     entries_o,
  output logic              dir_o
);
  logic [TOT_W-1:0]               total;
  logic [NDESC-1:0][ADDR_W-1:0]   base;
  logic [NDESC-1:0][ROOM_W-1:0]   cnt;
  logic [UW-1:0]                  used;

  dlb_size_calc #(.SEC_W(SEC_W), .SECT_LG(SECT_LG)) u_size (
    .sectors_i(sectors_i),
    .total_o  (total)
  );

  dlb_region_split #(
    .ADDR_W(ADDR_W), .TOT_W(TOT_W), .PAGE_LG(PAGE_LG), .NDESC(NDESC)
  ) u_split (
    .addr_i (addr_i),
    .total_i(total),
    .base_o (base),
    .cnt_o  (cnt),
    .used_o (used)
  );

  dlb_word_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_LG(PAGE_LG), .NDESC(NDESC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .odd_i    (addr_i[0]),
    .dir_i    (dir_i),
    .base_i   (base),
    .cnt_i    (cnt),
    .used_i   (used),
    .wr_en_o  (wr_en_o),
    .wr_idx_o (wr_idx_o),
    .wr_data_o(wr_data_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .entries_o(entries_o),
    .dir_o    (dir_o)
  );
endmodule

// File: rtl/dlb_checker.sv
module dlb_checker #(
  parameter int DATA_W  = 32,
  parameter int PAGE_LG = 16,
  parameter int NDESC   = 3,
  localparam int UW     = $clog2(NDESC + 1),
  localparam int IW     = $clog2(2 * NDESC)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_o,
  input logic [IW-1:0]     wr_idx_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [UW-1:0]     entries_o
);
  localparam logic [IW-1:0] LAST = IW'(2 * NDESC - 1);

  assert_idx_step_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_idx_o != LAST) |=> (wr_en_o && wr_idx_o == $past(wr_idx_o) + IW'(1)));

  assert_done_last_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_idx_o == LAST) |-> done_o);

  assert_err_silent_R1: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !wr_en_o);

  assert_flag_last_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_idx_o[0] && wr_data_o[DATA_W-1]) |->
      (int'(wr_idx_o) / 2 + 1 == int'(entries_o)));

  assert_mid_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_idx_o[0]) |-> (wr_data_o[DATA_W-2:PAGE_LG] == '0));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_idx_o[0] && (int'(wr_idx_o) / 2 >= int'(entries_o))) |-> (wr_data_o == '0));

  assert_entries_range_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (entries_o != '0 && int'(entries_o) <= NDESC));

  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(entries_o));
endmodule

bind dlb_builder dlb_checker #(.DATA_W(DATA_W), .PAGE_LG(PAGE_LG), .NDESC(NDESC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en_o  (wr_en_o),
  .wr_idx_o (wr_idx_o),
  .wr_data_o(wr_data_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .entries_o(entries_o)
);

// File: tb/sim_dlb_builder.sv
`timescale 1ns/1ps
module sim_dlb_builder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [7:0]  sectors_i = '0;
  logic        dir_i = 1'b0;
  logic        wr_en_o;
  logic [2:0]  wr_idx_o;
  logic [31:0] wr_data_o;
  logic        busy_o, done_o, err_o, dir_o;
  logic [1:0]  entries_o;

  int ntests = 0;
  int nfail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dlb_builder u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .sectors_i(sectors_i), .dir_i(dir_i), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .entries_o(entries_o), .dir_o(dir_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the table (R2, R3, R4, R5, R6, R7)
  function automatic void model(input logic [31:0] a, input logic [7:0] s,
                                output logic [5:0][31:0] w, output int n);
    longint tot, t1, t2, t3, rem;
    logic [31:0] a2, a3, r1;
    tot = ((s == 0) ? 256 : longint'(s)) * 512;
    a2  = (a & 32'hFFFF_0000) + 32'h0001_0000;
    a3  = a2 + 32'h0001_0000;
    r1  = a2 - a;
    n = 1; t1 = tot; t2 = 0; t3 = 0;
    if (tot > longint'(r1)) begin
      t1 = longint'(r1); rem = tot - t1; n = 2; t2 = rem;
      if (rem > 65536) begin
        t2 = 65536; t3 = rem - 65536; n = 3;
      end
    end
    w[0] = a;  w[1] = {(n == 1), 15'd0, t1[15:0]};
    w[2] = a2; w[3] = {(n == 2), 15'd0, t2[15:0]};
    w[4] = a3; w[5] = {(n == 3), 15'd0, t3[15:0]};
  endfunction

  task automatic run(input logic [31:0] a, input logic [7:0] s, input bit d, input bit inject);
    logic [5:0][31:0] ew;
    int en;
    model(a, s, ew, en);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; sectors_i = s; dir_i = d;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !wr_en_o, "R8 busy after accept", {30'd0, busy_o, wr_en_o}, 32'h2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(wr_en_o && wr_idx_o == 3'(k) && wr_data_o == ew[k],
          (k % 2 == 0) ? "R3 R8 base word" : "R2 R4 R5 R6 R7 count word",
          wr_data_o, ew[k]);
      chk(done_o == (k == 5), "R8 done timing", {31'd0, done_o}, {31'd0, k == 5});
      if (inject && k == 1) begin
        start_i = 1'b1; addr_i = 32'h0000_FFFE; sectors_i = 8'd0; dir_i = ~d;
      end else begin
        start_i = 1'b0;
      end
    end
    chk(entries_o == 2'(en), inject ? "R9 entries" : "R5 entries", {30'd0, entries_o}, en);
    chk(dir_o == d, inject ? "R9 dir" : "R10 dir", {31'd0, dir_o}, {31'd0, d});
    chk(!err_o, "R1 no error on even address", {31'd0, err_o}, 32'd0);
    @(negedge clk);
    chk(!wr_en_o && !done_o && !busy_o, "R8 quiet after table",
        {29'd0, wr_en_o, done_o, busy_o}, 32'd0);
  endtask

  task automatic run_odd(input logic [31:0] a);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; sectors_i = 8'd3; dir_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o && done_o && !wr_en_o && !busy_o && entries_o == 2'd0, "R1 odd address rejected",
        {27'd0, err_o, done_o, wr_en_o, busy_o, entries_o != 0}, 32'h18);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!wr_en_o && err_o && !done_o, "R1 nothing written",
          {29'd0, wr_en_o, err_o, done_o}, 32'h2);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en_o && !busy_o && !done_o && !err_o && entries_o == 0, "R8 reset state",
        {27'd0, wr_en_o, busy_o, done_o, err_o, entries_o != 0}, 32'd0);
    run(32'h0000_0000, 8'd1, 1'b0, 1'b0);   // R4 single entry
    run(32'h0001_0000, 8'd0, 1'b1, 1'b0);   // R2 R6 two full pages
    run(32'h0000_FFFE, 8'd0, 1'b0, 1'b0);   // R4 three entries
    run(32'hFFFF_FFFE, 8'd4, 1'b1, 1'b0);   // R3 wrap
    run(32'h1234_FE00, 8'd1, 1'b0, 1'b0);   // R4 exact fit
    run(32'h0002_0000, 8'd2, 1'b1, 1'b1);   // R9 injected start
    run_odd(32'h0000_0101);                 // R1
    run(32'h0000_8000, 8'd64, 1'b1, 1'b0);  // R1 error cleared, R10
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a;
      logic [7:0]  s;
      a = $urandom() & 32'hFFFF_FFFE;
      if (i % 4 == 0) a = a | 32'h0000_FF00;
      s = 8'($urandom());
      run(a, s, 1'($urandom()), 1'b0);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      ntests++;
      nfail++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule